// File: doc/BRIEF.md
# Sigma-Delta Varactor Dither with Rate Select

This block turns a fixed-point oscillator tuning word into an integer tuning word plus a one-bit dither. A first-order sigma-delta modulator adds the fractional part of the word into an accumulator on every update. The carry-out of that accumulator is the dither bit. It is added to the integer part of the word, and the dither bit itself drives the smallest varactor. Averaged over many updates, the integer output then equals the fixed-point input.

Updates happen on a divided version of the oscillator clock, so the dither stays frequency-synchronous with the oscillator. The divide ratio is a selectable power of two from 1 to 8. A delay setting with eight values picks the phase of the update relative to the oscillator, and it is presented as a tap index for an external delay line. Software sweeps this setting because performance depends on the update phase. A change of either setting takes effect only at the next update edge, and that edge also restarts the modulator from a cleared state.

Top module: `varactor_dither`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `int_tune`, `dither_bit` and `tap_idx` read zero. The active ratio and the active delay setting reset to 0.
- R2: With the active rate code r, update edges occur every 2^r oscillator cycles: codes 0, 1, 2 and 3 give ratios 1, 2, 4 and 8. After reset, the first update is at the first clock edge. Outputs change only on update edges.
- R3: The tuning word is sampled only on update edges. A change between update edges has no effect on any output.
- R4: The tuning word is laid out as integer part in bits [15:8] and fraction in bits [7:0]. On each update, the 8-bit accumulator adds the fraction. `dither_bit` is the carry-out of that addition, and the accumulator keeps the low 8 bits.
- R5: `int_tune` is 9 bits wide and equals the sampled integer part plus `dither_bit`. With integer part 0xFF and a carry, it reads 0x100.
- R6: A fraction of zero gives a dither bit of zero on every update.
- R7: A fraction of 0xFF gives a one on exactly 255 of 256 consecutive updates after a clear.
- R8: Over 256 consecutive updates that follow a clear, with a constant fraction F, the dither bit is one exactly F times.
- R9: When `rate_sel` or `delay_sel` differs from the active setting, nothing changes until the next update edge. At that edge the new settings become active, the accumulator clears, `dither_bit` reads 0 and `int_tune` takes the new integer part. The new ratio counts from that edge.
- R10: `tap_idx` shows the active delay setting (0 to 7) and changes only on update edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | 16 | Fixed-point tuning word: integer part in [15:8], fraction in [7:0] |
| rate_sel | input | 2 | Update ratio code; the ratio is 2^code |
| delay_sel | input | 3 | Requested update-phase delay setting |
| int_tune | output | 9 | Integer tuning word including the dither carry |
| dither_bit | output | 1 | One-bit dither for the least-significant varactor |
| tap_idx | output | 3 | Active delay tap index for the external delay line |

## Verification
The bench builds the block with its default 8-bit integer and 8-bit fraction widths. At these widths a full 256-update modulator cycle takes at most 2048 oscillator cycles even at the slowest ratio, so the exact count of ones over a whole cycle can be checked for zero, mid and full-scale fractions. The widths also reach the case where the carry lifts an integer part of 0xFF into the ninth output bit. Randomised words and setting changes land at every phase of the divider, which exercises deferred reconfiguration and sampling between edges at all four ratios.

// File: rtl/vd_pkg.sv
package vd_pkg;
    localparam int RATE_W = 2;
    localparam int TAP_W  = 3;
    localparam int CNT_W  = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [TAP_W-1:0]  tap;
    } vd_cfg_t;

    function automatic logic [CNT_W-1:0] last_count(input logic [RATE_W-1:0] r);
        last_count = CNT_W'((1 << r) - 1);
    endfunction
endpackage

// File: rtl/vd_rate_div.sv
module vd_rate_div
    import vd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = last_count(rate);
    assign tick  = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);
endmodule

// File: rtl/vd_cfg.sv
module vd_cfg
    import vd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  vd_cfg_t cfg_in,
    output vd_cfg_t cfg_q,
    output logic    reload
);
    assign reload = tick && (cfg_in != cfg_q);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (reload) cfg_q <= cfg_in;
    end

    // R10
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cfg_q.tap));
endmodule

// File: rtl/vd_sd_accum.sv
module vd_sd_accum #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step,
    input  logic                    clear,
    input  logic [INT_W+FRAC_W-1:0] word_in,
    output logic [INT_W:0]          int_out,
    output logic                    dither_q
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] frac;
    logic [INT_W-1:0]  ipart;
    logic [FRAC_W:0]   sum;

    assign frac  = word_in[FRAC_W-1:0];
    assign ipart = word_in[INT_W+FRAC_W-1:FRAC_W];
    assign sum   = {1'b0, acc} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            dither_q <= 1'b0;
            int_out  <= '0;
        end else if (clear) begin
            acc      <= '0;
            dither_q <= 1'b0;
            int_out  <= {1'b0, ipart};
        end else if (step) begin
            acc      <= sum[FRAC_W-1:0];
            dither_q <= sum[FRAC_W];
            int_out  <= {1'b0, ipart} + {{INT_W{1'b0}}, sum[FRAC_W]};
        end
    end

    // R6
    zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && frac == '0) |=> !dither_q);

    // R9
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0 && !dither_q));
endmodule

// File: rtl/varactor_dither.sv
module varactor_dither
    import vd_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [INT_W+FRAC_W-1:0] tune_word,
    input  logic [RATE_W-1:0]       rate_sel,
    input  logic [TAP_W-1:0]        delay_sel,
    output logic [INT_W:0]          int_tune,
    output logic                    dither_bit,
    output logic [TAP_W-1:0]        tap_idx
);
    vd_cfg_t cfg_in;
    vd_cfg_t cfg_q;
    logic    tick;
    logic    reload;

    assign cfg_in.rate = rate_sel;
    assign cfg_in.tap  = delay_sel;
    assign tap_idx     = cfg_q.tap;

    vd_rate_div u_div (
        .clk  (clk),
        .rst  (rst),
        .rate (cfg_q.rate),
        .tick (tick)
    );

    vd_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .reload (reload)
    );

    vd_sd_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .step     (tick),
        .clear    (reload),
        .word_in  (tune_word),
        .int_out  (int_tune),
        .dither_q (dither_bit)
    );

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(int_tune) && $stable(dither_bit)));
endmodule

// File: tb/varactor_dither_test.sv
module varactor_dither_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tune;
    logic [1:0]  rate_sel;
    logic [2:0]  dly_sel;
    logic [8:0]  int_tune;
    logic        dither_bit;
    logic [2:0]  tap_idx;

    always #5 clk = ~clk;

    varactor_dither uut (
        .clk        (clk),
        .rst        (rst),
        .tune_word  (tune),
        .rate_sel   (rate_sel),
        .delay_sel  (dly_sel),
        .int_tune   (int_tune),
        .dither_bit (dither_bit),
        .tap_idx    (tap_idx)
    );

    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    int         m_cnt;
    int         m_acc;
    logic [1:0] m_rate;
    logic [2:0] m_tap;
    logic [8:0] m_int;
    logic       m_dith;
    logic       m_tick;
    logic       m_reload;
    int         upd;
    int         ones;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic int ratio_last(input logic [1:0] r);
        return (1 << r) - 1;
    endfunction

    task automatic step();
        @(posedge clk);
        m_tick   = 1'b0;
        m_reload = 1'b0;
        if (rst) begin
            m_cnt = 0; m_acc = 0; m_rate = '0; m_tap = '0; m_int = '0; m_dith = 1'b0;
        end else if (m_cnt == ratio_last(m_rate)) begin
            m_tick = 1'b1;
            m_cnt  = 0;
            if (rate_sel != m_rate || dly_sel != m_tap) begin
                m_reload = 1'b1;
                m_rate   = rate_sel;
                m_tap    = dly_sel;
                m_acc    = 0;
                m_dith   = 1'b0;
                m_int    = {1'b0, tune[15:8]};
            end else begin
                m_acc  = m_acc + int'(tune[7:0]);
                m_dith = (m_acc >= 256);
                m_acc  = m_acc % 256;
                m_int  = {1'b0, tune[15:8]} + {8'd0, m_dith};
            end
        end else begin
            m_cnt++;
        end
        #1;
        cycles++;
        check(int_tune == m_int && dither_bit == m_dith && tap_idx == m_tap,
              "R2 R3 R4 R5 R10 cycle outputs",
              int'({int_tune, dither_bit, tap_idx}), int'({m_int, m_dith, m_tap}));
        if (m_tick && !m_reload) begin
            upd++;
            ones += int'(dither_bit);
        end
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    endtask

    task automatic run_window(input logic [1:0] r, input logic [2:0] t,
                              input logic [15:0] w, input int n);
        rate_sel = r;
        dly_sel  = t;
        tune     = w;
        do step(); while (!m_reload);
        upd  = 0;
        ones = 0;
        while (upd < n) step();
    endtask

    initial begin
        logic [8:0] held_int;
        logic       held_d;
        logic       prev_d;
        int         toggles;
        void'($urandom(32'd1234));
        rst = 1'b1; tune = 16'hABCD; rate_sel = 2'd2; dly_sel = 3'd6;
        repeat (3) step();
        // R1: reset state
        check(int_tune == 9'd0 && dither_bit == 1'b0 && tap_idx == 3'd0,
              "R1 reset outputs", int'({int_tune, dither_bit, tap_idx}), 0);
        tune = 16'h0000; rate_sel = 2'd0; dly_sel = 3'd0;
        rst = 1'b0;
        step();
        check(int_tune == 9'd0 && dither_bit == 1'b0 && tap_idx == 3'd0,
              "R1 first cycle after reset", int'({int_tune, dither_bit, tap_idx}), 0);

        // R6: zero fraction
        run_window(2'd0, 3'd1, 16'h1200, 256);
        check(ones == 0, "R6 zero fraction ones", ones, 0);

        // R7: full-scale fraction
        run_window(2'd1, 3'd2, 16'h34FF, 256);
        check(ones == 255, "R7 full fraction ones", ones, 255);

        // R8: quarter fraction at slowest ratio
        run_window(2'd3, 3'd5, 16'h0740, 256);
        check(ones == 64, "R8 fraction 0x40 ones", ones, 64);

        // R8: odd fraction
        run_window(2'd2, 3'd7, 16'h00A5, 256);
        check(ones == 165, "R8 fraction 0xA5 ones", ones, 165);

        // R5: integer overflow into the ninth bit
        run_window(2'd0, 3'd3, 16'hFF80, 2);
        check(int_tune == 9'h100 && dither_bit == 1'b1, "R5 carry into bit 8",
              int'(int_tune), 9'h100);

        // R2: ratio 4 with alternating dither
        run_window(2'd2, 3'd4, 16'h1180, 0);
        toggles = 0;
        prev_d  = dither_bit;
        repeat (40) begin
            step();
            if (dither_bit != prev_d) toggles++;
            prev_d = dither_bit;
        end
        check(toggles == 9, "R2 dither transitions at ratio 4", toggles, 9);

        // R3: word changes between update edges are ignored
        run_window(2'd3, 3'd5, 16'h2233, 0);
        held_int = int_tune;
        held_d   = dither_bit;
        for (int i = 0; i < 7; i++) begin
            tune = 16'($urandom);
            step();
        end
        check(int_tune == held_int && dither_bit == held_d, "R3 hold between edges",
              int'({int_tune, dither_bit}), int'({held_int, held_d}));

        // R9: deferred setting change
        tune = 16'h5570;
        run_window(2'd3, 3'd6, 16'h5570, 3);
        dly_sel = 3'd2;
        step();
        check(tap_idx == 3'd6, "R9 delay change deferred", int'(tap_idx), 6);
        do step(); while (!m_reload);
        check(tap_idx == 3'd2 && dither_bit == 1'b0 && int_tune == 9'h055,
              "R9 reload clears dither and applies tap",
              int'({int_tune, dither_bit, tap_idx}), int'({9'h055, 1'b0, 3'd2}));

        // R10 R4: random words and settings at every divider phase
        for (int i = 0; i < 4000; i++) begin
            tune = 16'($urandom);
            if (($urandom % 50) == 0) begin
                rate_sel = 2'($urandom);
                dly_sel  = 3'($urandom);
            end
            step();
        end
        check(tap_idx == m_tap, "R10 tap after random run", int'(tap_idx), int'(m_tap));

        finish_run();
    end
endmodule